// File: doc/BRIEF.md
# Load Result Alignment Formatter

This block sits at the end of a load pipeline. It takes the raw item fetched from storage, already right-justified in a 64-bit bus, and shapes it into the value written to the target register. It handles three kinds of shaping. The item can be zero-extended, or sign-extended from its most significant bit. For the halfword, word and doubleword sizes, the byte order of the item can instead be reversed. Address generation, the storage access and alignment checks all happen upstream.

Bits are described big-endian, with bit 0 as the most significant. On the ports, `out_data[7:0]` carries result bits 56:63 and `out_data[63:56]` carries result bits 0:7. Storage byte 0 of an item of N bytes is the most significant byte of the right-justified input, `in_data[8N-1:8N-8]`.

The formatter is a single registered stage. A request presented with `in_valid` produces its result one clock later. A reversal request that is not permitted is flagged as an error, and its result is forced to zero.

Top module: `load_result_fmt`

## Requirements
- R1: With `in_size`=0 (byte), `in_sext`=0 and `in_brev`=0, the result holds `in_data[7:0]` in bits 56:63, and bits 0:55 are zero.
- R2: With `in_size`=0, `in_sext`=1 and `in_brev`=0, bits 0:55 of the result are copies of the byte's top bit `in_data[7]`.
- R3: With `in_size`=1 (halfword) and `in_brev`=0, the result holds `in_data[15:0]` in bits 48:63. Bits 0:47 are zero when `in_sext`=0, and copies of `in_data[15]` when `in_sext`=1.
- R4: With `in_size`=2 (word) and `in_brev`=0, the result holds `in_data[31:0]` in bits 32:63. Bits 0:31 are zero when `in_sext`=0, and copies of `in_data[31]` when `in_sext`=1.
- R5: With `in_size`=3 (doubleword) and `in_brev`=0, the result equals `in_data` unchanged, whatever the value of `in_sext`.
- R6: With `in_size`=1, `in_brev`=1 and `in_sext`=0, storage byte 0 (`in_data[15:8]`) goes to bits 56:63 and storage byte 1 goes to bits 48:55. Bits 0:47 are zero.
- R7: With `in_size`=2, `in_brev`=1 and `in_sext`=0, storage bytes 0, 1, 2 and 3 go to bits 56:63, 48:55, 40:47 and 32:39. Bits 0:31 are zero.
- R8: With `in_size`=3, `in_brev`=1 and `in_sext`=0, storage byte k (for k from 0 to 7) goes to result bits 56-8k through 63-8k.
- R9: A request with `in_brev`=1 together with either `in_sext`=1 or `in_size`=0 is illegal. It produces `out_err`=1 and a result of all zeros. Every legal request produces `out_err`=0.
- R10: `out_valid` is `in_valid` delayed by one clock. `out_data` and `out_err` update only for a valid request, and hold their values while `in_valid` is low.
- R11: A synchronous active-high `rst` clears `out_valid`, `out_err` and `out_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_size | input | 2 | Item size: 0 byte, 1 halfword, 2 word, 3 doubleword |
| in_sext | input | 1 | Sign-extend from the item's top bit |
| in_brev | input | 1 | Reverse the byte order of the item |
| in_data | input | 64 | Right-justified storage item |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_data | output | 64 | Formatted register value |
| out_err | output | 1 | Illegal combination of controls |

## Verification
Two functions can be requested in the same cycle: byte reversal and sign extension. A byte reversal can also be combined with the byte size. Both combinations are provoked by sweeping every combination of size, extension and reversal over data patterns whose sign bits are set in every byte lane. Each such case is judged by requiring the error flag and an all-zero result, so no stray sign fill or swapped byte can leak through. Every legal combination in the same sweep is compared against a value the bench computes with shifts and masks.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
  localparam int XLEN_DEF = 64;
  localparam int LANE_W   = 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } size_e;
endpackage

// File: rtl/lrf_extend.sv
module lrf_extend #(
  parameter int XLEN = lrf_pkg::XLEN_DEF
) (
  input  logic [$clog2($clog2(XLEN/lrf_pkg::LANE_W)+1)-1:0] size,
  input  logic                                              sext,
  input  logic [XLEN-1:0]                                   data,
  output logic [XLEN-1:0]                                   result
);
  localparam int NB    = XLEN / lrf_pkg::LANE_W;
  localparam int LOGNB = $clog2(NB);

  logic [XLEN-1:0] cand [LOGNB+1];

  // One candidate per item size; the widest one passes straight through.
  for (genvar k = 0; k <= LOGNB; k++) begin : g_size
    localparam int W = lrf_pkg::LANE_W << k;
    if (W >= XLEN) begin : g_full
      assign cand[k] = data;
    end else begin : g_part
      assign cand[k] = {{(XLEN-W){sext & data[W-1]}}, data[W-1:0]};
    end
  end

  assign result = cand[size];
endmodule

// File: rtl/lrf_byte_swap.sv
module lrf_byte_swap #(
  parameter int XLEN = lrf_pkg::XLEN_DEF
) (
  input  logic [$clog2($clog2(XLEN/lrf_pkg::LANE_W)+1)-1:0] size,
  input  logic [XLEN-1:0]                                   data,
  output logic [XLEN-1:0]                                   result
);
  localparam int LW    = lrf_pkg::LANE_W;
  localparam int NB    = XLEN / LW;
  localparam int LOGNB = $clog2(NB);

  logic [XLEN-1:0] cand [LOGNB+1];

  // Reverse the low 2^k lanes for each size k, clearing the lanes above.
  for (genvar k = 0; k <= LOGNB; k++) begin : g_size
    localparam int N = 1 << k;
    for (genvar b = 0; b < NB; b++) begin : g_lane
      if (b < N) begin : g_in
        assign cand[k][b*LW +: LW] = data[(N-1-b)*LW +: LW];
      end else begin : g_out
        assign cand[k][b*LW +: LW] = '0;
      end
    end
  end

  assign result = cand[size];
endmodule

// File: rtl/load_result_fmt.sv
module load_result_fmt #(
  parameter int XLEN = lrf_pkg::XLEN_DEF,
  localparam int NB  = XLEN / lrf_pkg::LANE_W,
  localparam int SZW = $clog2($clog2(NB)+1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [SZW-1:0]  in_size,
  input  logic            in_sext,
  input  logic            in_brev,
  input  logic [XLEN-1:0] in_data,
  output logic            out_valid,
  output logic [XLEN-1:0] out_data,
  output logic            out_err
);
  import lrf_pkg::*;

  localparam logic [SZW-1:0] SZ_MIN = '0;
  localparam logic [SZW-1:0] SZ_MAX = SZW'($clog2(NB));

  logic [XLEN-1:0] ext_val;
  logic [XLEN-1:0] swp_val;
  logic            illegal;
  logic [XLEN-1:0] next_val;

  lrf_extend #(.XLEN(XLEN)) u_ext (
    .size   (in_size),
    .sext   (in_sext),
    .data   (in_data),
    .result (ext_val)
  );

  lrf_byte_swap #(.XLEN(XLEN)) u_swp (
    .size   (in_size),
    .data   (in_data),
    .result (swp_val)
  );

  assign illegal  = in_brev & (in_sext | (in_size == SZ_MIN));
  assign next_val = illegal ? '0 : (in_brev ? swp_val : ext_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= next_val;
        out_err  <= illegal;
      end
    end
  end

  AST_VALID_LAG: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_err))); // R10
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_err |-> (out_data == '0)); // R9
  AST_BAD_COMBO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_brev && (in_sext || in_size == SZ_MIN)) |=> out_err); // R9
  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_size == SZ_MIN && !in_sext && !in_brev)
      |=> (out_data[XLEN-1:lrf_pkg::LANE_W] == '0)); // R1
  AST_DWORD_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_size == SZ_MAX && !in_brev) |=> (out_data == $past(in_data))); // R5
endmodule

// File: tb/load_result_fmt_bench.sv
module load_result_fmt_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  in_size;
  logic        in_sext;
  logic        in_brev;
  logic [63:0] in_data;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_err;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  load_result_fmt u_load_result_fmt (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_size(in_size),
    .in_sext(in_sext), .in_brev(in_brev), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input int sz, input bit sx, input bit br);
    if (br && (sx || sz == 0)) return "R9";
    if (br) return (sz == 1) ? "R6" : (sz == 2) ? "R7" : "R8";
    case (sz)
      0: return sx ? "R2" : "R1";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic [64:0] model(input int sz, input bit sx, input bit br, input logic [63:0] d);
    int nb = 1 << sz;
    int w  = 8 * nb;
    logic [63:0] m;
    logic [63:0] r = '0;
    if (br && (sx || sz == 0)) return {1'b1, 64'd0};
    if (br) begin
      for (int b = 0; b < nb; b++)
        r = r | (((d >> (8*b)) & 64'hFF) << (8*(nb-1-b)));
      return {1'b0, r};
    end
    m = (w == 64) ? ~64'd0 : ((64'd1 << w) - 64'd1);
    r = d & m;
    if (sx && w < 64 && ((d >> (w-1)) & 64'd1) == 64'd1) r = r | ~m;
    return {1'b0, r};
  endfunction

  initial begin
    #(4 * 5000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] pats [6];
    logic [64:0] e;
    logic [63:0] held;
    pats[0] = 64'h0123_4567_89AB_CDEF;
    pats[1] = 64'hFEDC_BA98_7654_3210;
    pats[2] = 64'h0000_0000_0000_0000;
    pats[3] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[4] = 64'h8000_0000_8000_8080;
    pats[5] = 64'h7F7F_7F7F_7F7F_7F7F;

    rst = 1'b1; in_valid = 1'b0; in_size = '0; in_sext = 1'b0; in_brev = 1'b0;
    in_data = 64'hDEAD_BEEF_DEAD_BEEF;
    repeat (3) @(negedge clk);
    check("R11 out_valid", {63'd0, out_valid}, 64'd0);
    check("R11 out_data", out_data, 64'd0);
    check("R11 out_err", {63'd0, out_err}, 64'd0);
    rst = 1'b0;

    for (int p = 0; p < 6; p++)
      for (int sz = 0; sz < 4; sz++)
        for (int sx = 0; sx < 2; sx++)
          for (int br = 0; br < 2; br++) begin
            in_valid = 1'b1; in_size = 2'(sz); in_sext = 1'(sx); in_brev = 1'(br);
            in_data = pats[p];
            e = model(sz, 1'(sx), 1'(br), pats[p]);
            @(negedge clk);
            in_valid = 1'b0; in_data = ~pats[p]; in_brev = 1'b0; in_sext = 1'b1;
            check({req_of(sz, 1'(sx), 1'(br)), " data"}, out_data, e[63:0]);
            check({req_of(sz, 1'(sx), 1'(br)), " err R9"}, {63'd0, out_err}, {63'd0, e[64]});
            check("R10 valid lag", {63'd0, out_valid}, 64'd1);
            held = out_data;
            @(negedge clk);
            check("R10 idle valid", {63'd0, out_valid}, 64'd0);
            check("R10 idle hold", out_data, held);
          end

    // back-to-back requests: each result appears one clock after its request
    for (int i = 0; i < 4; i++) begin
      in_valid = 1'b1; in_size = 2'(i); in_sext = 1'b1; in_brev = 1'b0;
      in_data = pats[4];
      @(negedge clk);
      e = model(i, 1'b1, 1'b0, pats[4]);
      check("R10 back-to-back", out_data, e[63:0]);
    end
    in_valid = 1'b0;

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11 reset after use", out_data, 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule